// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Run-Time Framing

This block takes bytes from a host and sends them out as asynchronous serial frames on a single line. Each frame opens with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and the frame closes with a high stop period. Character length, parity kind and stop length are inputs that may change between frames. Each frame captures its settings when it begins. All bit timing comes from an oversampling tick that runs at sixteen times the bit rate. A 16-bit divisor of the system clock sets the rate of that tick.

Characters wait in a queue before they are sent. In deep mode the queue holds up to 64 characters. In single mode it holds just one character. When the mode input changes, the queue is emptied. The host sees two flags. One reports that the queue is empty. The other reports that the transmitter has completely finished. A break input pulls the line low for as long as it stays asserted.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line is high, `buf_empty` is 1 and `tx_idle` is 1.
- R2: A frame is sent as a start bit at 0, then the data bits least significant first, then the stop period at 1. Start, data and parity bits each last 16 ticks.
- R3: `char_len` selects the number of data bits: code 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits above the selected length are not sent.
- R4: `par_mode` selects the parity bit that follows the data. Code 1 gives odd parity, so the data ones plus the parity bit form an odd count. Code 2 gives even parity. Codes 0 and 3 send no parity bit.
- R5: With `stop_long` at 0 the stop period lasts 16 ticks. With `stop_long` at 1 it lasts 24 ticks for 5-bit characters and 32 ticks for every other length.
- R6: A tick occurs once every `divisor` clock cycles, and a divisor of 0 acts as 1. With a divisor of 3 the start bit therefore lasts 48 cycles.
- R7: With `fifo_en` at 1 the queue holds 64 characters and sends them in the order they were written. A write while 64 characters are waiting is ignored and leaves the queued data unchanged.
- R8: With `fifo_en` at 0 the queue holds one character. A write while that character is waiting is ignored.
- R9: While `brk` is 1, `txd` is 0. When `brk` returns to 0, the line goes back to its normal value.
- R10: `tx_idle` is 1 only when the queue is empty and the stop period of the last frame has ended. Frames waiting in the queue are sent back to back, with no idle gap between them.
- R11: A change of `fifo_en` discards every character that has not yet started, which leaves `buf_empty` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| divisor | input | 16 | Clock cycles per oversampling tick (0 acts as 1) |
| char_len | input | 2 | Data bit count code (5 plus the code) |
| par_mode | input | 2 | 0/3 no parity, 1 odd, 2 even |
| stop_long | input | 1 | 0 one stop bit, 1 long stop period |
| fifo_en | input | 1 | 1 selects the 64-deep queue, 0 the single holding slot |
| brk | input | 1 | Forces the line low while high |
| wr_en | input | 1 | Writes `wr_data` into the queue |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, high when idle |
| buf_empty | output | 1 | No character waiting |
| tx_idle | output | 1 | Queue empty and last frame finished |

## Verification
The bench attacks the edges of the frame. It checks that the 1.5-stop setting gives 24 ticks only for 5-bit characters, so a design that applied it to every length would stretch or shorten the stop period. It checks the parity sense in both directions. An inverted parity calculation would fail the odd case and the even case alike. It fills the deep queue exactly, then writes one more character. A design that overwrote the oldest entry, or that let the extra character through, would show a corrupt first frame or a 65th frame. It also checks that `tx_idle` stays low through the final stop tick, that a mode change empties the queue, and that the tick period scales with the divisor, with 0 acting as 1.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned STOP_W        = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [3:0]        nbits;
        logic              par_en;
        logic              par_odd;
        logic [STOP_W-1:0] stop_ticks;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_cfg(
        input logic [1:0] len_code,
        input logic [1:0] par_code,
        input logic       stop_long
    );
        frame_cfg_t c;
        c.nbits   = 4'd5 + {2'b00, len_code};
        c.par_en  = (par_code == 2'd1) || (par_code == 2'd2);
        c.par_odd = (par_code == 2'd1);
        if (!stop_long)
            c.stop_ticks = STOP_W'(16);
        else if (len_code == 2'd0)
            c.stop_ticks = STOP_W'(24);
        else
            c.stop_ticks = STOP_W'(32);
        return c;
    endfunction

    function automatic logic parity_bit(
        input logic [7:0] data,
        input logic [3:0] nbits,
        input logic       odd
    );
        logic [7:0] mask;
        mask = 8'hFF >> (4'd8 - nbits);
        return (^(data & mask)) ^ odd;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (divisor == '0) ? '0 : divisor - 1'b1;
        tick  = (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap;
    logic             mode_q;
    logic             flush, full, do_wr, do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        flush   = (fifo_en != mode_q);
        empty   = (count == '0);
        full    = (count >= cap);
        do_wr   = wr_en && !full && !flush;
        do_rd   = rd_en && !empty && !flush;
        rd_data = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_wr && !rst)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            mode_q <= fifo_en;
        end else begin
            mode_q <= fifo_en;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (do_wr) wr_ptr <= bump(wr_ptr);
                if (do_rd) rd_ptr <= bump(rd_ptr);
                case ({do_wr, do_rd})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg_in,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       pop,
    output logic       line,
    output logic       busy
);
    tx_state_e         state;
    frame_cfg_t        cfg;
    logic [7:0]        shreg;
    logic [3:0]        bit_idx;
    logic [STOP_W-1:0] tcnt;
    logic              par_q;
    logic              bit_end, stop_end;

    always_comb begin
        bit_end  = (tcnt == STOP_W'(TICKS_PER_BIT - 1));
        stop_end = (state == ST_STOP) && (tcnt == cfg.stop_ticks - 1'b1);
        pop      = tick && !q_empty && ((state == ST_IDLE) || stop_end);
        busy     = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg     <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            tcnt    <= '0;
            par_q   <= 1'b0;
            line    <= 1'b1;
        end else if (pop) begin
            state   <= ST_START;
            cfg     <= cfg_in;
            shreg   <= q_data;
            par_q   <= parity_bit(q_data, cfg_in.nbits, cfg_in.par_odd);
            bit_idx <= '0;
            tcnt    <= '0;
            line    <= 1'b0;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    tcnt <= '0;
                    line <= 1'b1;
                end
                ST_START: if (bit_end) begin
                    state <= ST_DATA;
                    tcnt  <= '0;
                    line  <= shreg[0];
                end
                ST_DATA: if (bit_end) begin
                    tcnt <= '0;
                    if (bit_idx == cfg.nbits - 1'b1) begin
                        state <= cfg.par_en ? ST_PAR : ST_STOP;
                        line  <= cfg.par_en ? par_q : 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= shreg >> 1;
                        line    <= shreg[1];
                    end
                end
                ST_PAR: if (bit_end) begin
                    state <= ST_STOP;
                    tcnt  <= '0;
                    line  <= 1'b1;
                end
                ST_STOP: if (stop_end) begin
                    state <= ST_IDLE;
                    tcnt  <= '0;
                    line  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       char_len,
    input  logic [1:0]       par_mode,
    input  logic             stop_long,
    input  logic             fifo_en,
    input  logic             brk,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             txd,
    output logic             buf_empty,
    output logic             tx_idle
);
    logic       tick, pop, line, frame_busy, q_empty;
    logic [7:0] q_data;
    frame_cfg_t cfg_now;

    assign cfg_now = decode_cfg(char_len, par_mode, stop_long);

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
    );

    uart_tx_queue #(.DEPTH(DEPTH), .DW(8)) u_queue (
        .clk(clk), .rst(rst), .fifo_en(fifo_en),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .rd_data(q_data), .empty(q_empty)
    );

    uart_tx_frame u_frame (
        .clk(clk), .rst(rst), .tick(tick), .cfg_in(cfg_now),
        .q_empty(q_empty), .q_data(q_data),
        .pop(pop), .line(line), .busy(frame_busy)
    );

    assign txd       = line && !brk;
    assign buf_empty = q_empty;
    assign tx_idle   = q_empty && !frame_busy;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic brk,
    input logic fifo_en,
    input logic txd,
    input logic buf_empty,
    input logic tx_idle
);
    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_idle && buf_empty));

    // R9
    brk_low_chk: assert property (@(posedge clk) disable iff (rst)
        brk |-> !txd);

    // R10
    idle_means_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> buf_empty);

    // R10
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_idle && !brk) |-> txd);

    // R11
    mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en != $past(fifo_en)) |=> buf_empty);
endmodule

bind uart_tx_framer uart_tx_chk u_chk (
    .clk(clk), .rst(rst), .brk(brk), .fifo_en(fifo_en),
    .txd(txd), .buf_empty(buf_empty), .tx_idle(tx_idle)
);

// File: tb/sim_uart_tx_framer.sv
module sim_uart_tx_framer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] divisor = 16'd1;
    logic [1:0]  char_len = 2'd3;
    logic [1:0]  par_mode = 2'd0;
    logic        stop_long = 1'b0;
    logic        fifo_en = 1'b1;
    logic        brk = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        txd, buf_empty, tx_idle;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    uart_tx_framer u0 (
        .clk(clk), .rst(rst), .divisor(divisor), .char_len(char_len),
        .par_mode(par_mode), .stop_long(stop_long), .fifo_en(fifo_en),
        .brk(brk), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .buf_empty(buf_empty), .tx_idle(tx_idle)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] dv, input logic fen);
        @(negedge clk);
        rst = 1'b1; divisor = dv; fifo_en = fen; brk = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_cfg(input int n, input int pm, input bit sl);
        char_len  = 2'(n - 5);
        par_mode  = 2'(pm);
        stop_long = sl;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Samples one frame at one tick per cycle; sample 0 is the first low sample.
    task automatic capture(input int n, input int pm, input bit sl,
                           input logic [7:0] d, input string tag);
        int  stk, nslots, total, guard;
        bit  p_en;
        logic pbit, expv;
        logic [7:0] md;
        p_en   = (pm == 1) || (pm == 2);
        stk    = sl ? ((n == 5) ? 24 : 32) : 16;
        nslots = 1 + n + (p_en ? 1 : 0);
        total  = 16 * nslots + stk;
        md     = d & 8'(((1 << n) - 1));
        pbit   = (^md) ^ (pm == 1);
        guard  = 0;
        @(negedge clk);
        while (txd !== 1'b0 && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 400, {tag, " start seen"}, guard, 0);
        for (int c = 0; c < total; c++) begin
            if (c > 0) @(negedge clk);
            if (c % 16 == 8 && c < 16 * nslots) begin
                if (c / 16 == 0) expv = 1'b0;
                else if (c / 16 <= n) expv = d[c / 16 - 1];
                else expv = pbit;
                chk(txd === expv, {tag, " bit slot"}, int'(txd), int'(expv));
            end
            if (c == 16 * nslots + 8)
                chk(txd === 1'b1, {tag, " stop high"}, int'(txd), 1);
            if (c == total - 1)
                chk(txd === 1'b1 && tx_idle === 1'b0, {tag, " last stop tick busy"},
                    int'(tx_idle), 0);
        end
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        chk(tx_idle === 1'b1 && txd === 1'b1, {tag, " idle after stop"}, int'(tx_idle), 1);
    endtask

    task automatic t_reset;
        do_reset(16'd1, 1'b1);
        @(negedge clk);
        chk(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
        chk(buf_empty === 1'b1, "R1 buf_empty after reset", int'(buf_empty), 1);
        chk(tx_idle === 1'b1, "R1 tx_idle after reset", int'(tx_idle), 1);
    endtask

    task automatic t_frames;
        set_cfg(8, 0, 0); put(8'hA5); capture(8, 0, 0, 8'hA5, "R2 R3 8N1");
        expect_idle("R10 8N1");
        set_cfg(5, 2, 1); put(8'hF3); capture(5, 2, 1, 8'hF3, "R3 R4 R5 5E1.5");
        expect_idle("R5 5E1.5");
        set_cfg(6, 1, 0); put(8'h2D); capture(6, 1, 0, 8'h2D, "R4 6O1");
        expect_idle("R4 6O1");
        set_cfg(7, 2, 0); put(8'h07); capture(7, 2, 0, 8'h07, "R4 7E1");
        expect_idle("R4 7E1");
        set_cfg(7, 3, 1); put(8'h55); capture(7, 3, 1, 8'h55, "R5 7N2");
        expect_idle("R5 7N2");
        set_cfg(8, 1, 1); put(8'h00); capture(8, 1, 1, 8'h00, "R5 8O2");
        expect_idle("R5 8O2");
    endtask

    task automatic low_run(input logic [15:0] dv, input int exp, input string tag);
        int run, guard;
        do_reset(dv, 1'b1);
        set_cfg(8, 0, 0);
        put(8'hFF);
        guard = 0;
        while (txd !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
        run = 0;
        while (txd === 1'b0 && run < 400) begin @(negedge clk); run++; end
        chk(run == exp, tag, run, exp);
        guard = 0;
        while (tx_idle !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    endtask

    task automatic t_divisor;
        low_run(16'd3, 48, "R6 divisor 3 start length");
        low_run(16'd0, 16, "R6 divisor 0 start length");
    endtask

    task automatic t_break;
        int lows;
        do_reset(16'd1, 1'b1);
        @(negedge clk);
        brk = 1'b1;
        lows = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (txd === 1'b0) lows++;
        end
        chk(lows == 20, "R9 line held low during break", lows, 20);
        brk = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R9 line released after break", int'(txd), 1);
    endtask

    task automatic t_fifo;
        do_reset(16'hFFFF, 1'b1);
        set_cfg(8, 0, 0);
        for (int i = 0; i < 64; i++) put(8'(i * 3 + 1));
        chk(buf_empty === 1'b0, "R7 queue holds data", int'(buf_empty), 0);
        put(8'hEE);
        @(negedge clk);
        divisor = 16'd1;
        for (int i = 0; i < 64; i++) capture(8, 0, 0, 8'(i * 3 + 1), "R7 fifo order");
        expect_idle("R7 write to full queue ignored");
    endtask

    task automatic t_single;
        do_reset(16'hFFFF, 1'b0);
        set_cfg(8, 0, 0);
        put(8'h11);
        chk(buf_empty === 1'b0, "R8 holding slot full", int'(buf_empty), 0);
        put(8'h22);
        @(negedge clk);
        divisor = 16'd1;
        capture(8, 0, 0, 8'h11, "R8 held char");
        expect_idle("R8 second write ignored");
    endtask

    task automatic t_flush;
        int highs;
        do_reset(16'hFFFF, 1'b1);
        set_cfg(8, 0, 0);
        put(8'h5A); put(8'h5B); put(8'h5C);
        @(negedge clk);
        fifo_en = 1'b0;
        @(negedge clk);
        chk(buf_empty === 1'b1, "R11 mode change empties queue", int'(buf_empty), 1);
        divisor = 16'd1;
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd === 1'b1) highs++;
        end
        chk(highs == 100, "R11 nothing sent after flush", highs, 100);
        chk(tx_idle === 1'b1, "R11 idle after flush", int'(tx_idle), 1);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        fork
            begin
                t_reset();
                t_frames();
                t_divisor();
                t_break();
                t_fifo();
                t_single();
                t_flush();
            end
            begin
                wait (cyc >= 150000);
                nchk++;
                nfail++;
                $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            end
        join_any
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule